// File: doc/BRIEF.md
# Clock Output Divider with Half-Speed Bus Enable

This block turns one fast source clock into a fixed family of distributed clock outputs: a 2X clock, a set of in-phase 'Q' clocks at half the 2X rate, an inverted 'Q' clock, a feedback clock at half the 'Q' rate for a phase comparator, and a bus enable strobe. The strobe lets a processor clocked by the 2X output run its bus at half speed. The ratios are fixed. No input selects them.

All outputs are flip-flops clocked by the system clock `clk`. The block holds a three-bit phase counter. In normal mode (`pll_en` high) the counter advances on every `clk` cycle, so the 2X output has a period of two `clk` cycles. In test mode (`pll_en` low) the counter advances once for each rising edge of the asynchronous `ref_in`, after a two-stage synchronizer. The outputs then follow the reference through the same divide chain, and there is no lower limit on its frequency.

A synchronous reset sets the counter to phase 0 and sets each output to the value it has at that phase. The 'Q' and feedback clocks therefore always start in a known relation to the 2X clock.

Top module: `clkdiv_busen`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets phase 0 at that edge. At phase 0 `x2_clk`=1, every `q_clk` bit is 1, `q_clk_n`=0, `fb_clk`=1 and `bus_en`=1.
- R2: Each advance of the phase p (modulo 8) toggles `x2_clk`, with `x2_clk` = NOT p[0]. In normal mode p advances on every `clk` cycle, so `x2_clk` has a period of 2 `clk` cycles.
- R3: `q_clk` = NOT p[1]. Its period is twice that of `x2_clk`, and each rising edge of `q_clk` coincides with a rising edge of `x2_clk`.
- R4: All NUM_Q bits of `q_clk` are equal in every cycle.
- R5: `q_clk_n` is the logical inverse of `q_clk` in every cycle.
- R6: `fb_clk` = NOT p[2]. Its period is twice that of `q_clk`, and it rises only when `q_clk` rises.
- R7: `bus_en` is high when p mod 4 is 3 or 0, which is one `x2_clk` period out of every two. It changes only in cycles where `x2_clk` falls, so it is stable across the `x2_clk` rising edge at which `q_clk` rises.
- R8: With `pll_en` low, p advances by exactly one for each rising edge of `ref_in`. The outputs change on the third `clk` edge after `ref_in` rises, and they hold while `ref_in` stays at a constant level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the fast source in normal mode |
| rst | input | 1 | Synchronous active-high reset |
| pll_en | input | 1 | 1: advance on every clk cycle; 0: static test mode, advance on ref_in edges |
| ref_in | input | 1 | Asynchronous reference clock used in test mode |
| x2_clk | output | 1 | 2X clock output |
| q_clk | output | NUM_Q | In-phase 'Q' clocks at half the 2X rate |
| q_clk_n | output | 1 | Inverted 'Q' clock |
| fb_clk | output | 1 | Feedback clock at half the 'Q' rate |
| bus_en | output | 1 | Half-speed bus enable strobe |

## Verification
The test-mode path is the hardest to bring about. The counter moves only on synchronized rising edges of `ref_in`, so each advance comes three clock edges after the stimulus and cannot be told apart from a missed edge unless the bench holds `ref_in` steady around it. The bench therefore drives slow `ref_in` pulses with long high and low levels. It checks the outputs just before and just after the expected update edge, and again partway through each level, to confirm that one edge gives one step and a level gives none. The rule that the strobe never moves on a 2X rising edge is checked in every sampled cycle against the previous 2X value.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Phase counter width is fixed by the 2X/1X/0.5X family.
  localparam int PHASE_W = 3;
  typedef logic [PHASE_W-1:0] phase_t;

  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_FAST = 1'b1
  } src_mode_e;

  // Output values at phase 0, shared by reset and the out stage.
  localparam logic RST_X2 = 1'b1;
  localparam logic RST_Q  = 1'b1;
  localparam logic RST_FB = 1'b1;
  localparam logic RST_EN = 1'b1;
endpackage

// File: rtl/clkdiv_tick_gen.sv
module clkdiv_tick_gen
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_en,
  input  logic ref_in,
  output logic tick
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;
  src_mode_e          mode;

  assign mode = src_mode_e'(pll_en);

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN_W-2:0], ref_in};
  end

  logic ref_rise;
  assign ref_rise = chain[CHAIN_W-2] & ~chain[CHAIN_W-1];

  always_comb begin
    unique case (mode)
      SRC_FAST: tick = 1'b1;
      SRC_REF:  tick = ref_rise;
      default:  tick = 1'b0;
    endcase
  end

  // R8: one synchronized edge yields a single step
  p_single_step_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && !pll_en) |=> (!tick || pll_en));
endmodule

// File: rtl/clkdiv_phase_ctr.sv
module clkdiv_phase_ctr
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  output phase_t phase,
  output phase_t phase_nxt
);
  assign phase_nxt = adv ? phase + phase_t'(1) : phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase_nxt;
  end

  // R8: no advance request leaves the phase unchanged
  p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(phase));
  // R2: an advance moves the phase by one
  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> (phase == phase_t'($past(phase) + phase_t'(1))));
endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage
  import clkdiv_pkg::*;
#(
  parameter int NUM_Q = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  phase_t           phase_nxt,
  output logic             x2_clk,
  output logic [NUM_Q-1:0] q_clk,
  output logic             q_clk_n,
  output logic             fb_clk,
  output logic             bus_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x2_clk  <= RST_X2;
      q_clk_n <= ~RST_Q;
      fb_clk  <= RST_FB;
      bus_en  <= RST_EN;
    end else if (adv) begin
      x2_clk  <= ~phase_nxt[0];
      q_clk_n <= phase_nxt[1];
      fb_clk  <= ~phase_nxt[2];
      bus_en  <= ~(phase_nxt[1] ^ phase_nxt[0]);
    end
  end

  // One flop per in-phase output, as each drives its own tree.
  for (genvar g = 0; g < NUM_Q; g++) begin : g_qout
    always_ff @(posedge clk) begin
      if (rst)      q_clk[g] <= RST_Q;
      else if (adv) q_clk[g] <= ~phase_nxt[1];
    end
  end

  // R1: phase-0 values after a reset edge
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (x2_clk && (&q_clk) && !q_clk_n && fb_clk && bus_en));
  // R2: 2X output toggles on every advance
  p_x2_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    adv |=> (x2_clk != $past(x2_clk)));
  // R3: Q rises only together with 2X
  p_q_align_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(q_clk[0]) |-> $rose(x2_clk));
  // R4: in-phase outputs agree
  p_q_equal_r4: assert property (@(posedge clk) disable iff (rst)
    q_clk == {NUM_Q{q_clk[0]}});
  // R5: inverted copy
  p_q_inv_r5: assert property (@(posedge clk) disable iff (rst)
    q_clk_n == ~q_clk[0]);
  // R6: feedback rises only together with Q
  p_fb_align_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fb_clk) |-> $rose(q_clk[0]));
  // R7: strobe moves only where 2X falls
  p_en_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_en) |-> $fell(x2_clk));
  // R7: strobe is high around each Q rising edge
  p_en_at_qrise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(q_clk[0]) |-> bus_en);
endmodule

// File: rtl/clkdiv_busen.sv
module clkdiv_busen
  import clkdiv_pkg::*;
#(
  parameter int NUM_Q       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pll_en,
  input  logic             ref_in,
  output logic             x2_clk,
  output logic [NUM_Q-1:0] q_clk,
  output logic             q_clk_n,
  output logic             fb_clk,
  output logic             bus_en
);
  logic   tick;
  phase_t phase;
  phase_t phase_nxt;

  clkdiv_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .pll_en(pll_en), .ref_in(ref_in), .tick(tick)
  );

  clkdiv_phase_ctr u_ctr (
    .clk(clk), .rst(rst), .adv(tick), .phase(phase), .phase_nxt(phase_nxt)
  );

  clkdiv_out_stage #(.NUM_Q(NUM_Q)) u_out (
    .clk(clk), .rst(rst), .adv(tick), .phase_nxt(phase_nxt),
    .x2_clk(x2_clk), .q_clk(q_clk), .q_clk_n(q_clk_n),
    .fb_clk(fb_clk), .bus_en(bus_en)
  );

  // R8: in test mode with a steady reference the 2X output holds
  p_test_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!pll_en && !tick) |=> $stable(x2_clk));
  // R2: normal mode toggles the 2X output each cycle
  p_fast_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    pll_en |=> (x2_clk != $past(x2_clk)));
  // R6: feedback follows the top phase bit
  p_fb_phase_r6: assert property (@(posedge clk) disable iff (rst)
    fb_clk == ~phase[2]);
endmodule

// File: tb/clkdiv_busen_bench.sv
module clkdiv_busen_bench;
  localparam int NQ = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pll_en = 1'b1;
  logic          ref_in = 1'b0;
  logic          x2_clk;
  logic [NQ-1:0] q_clk;
  logic          q_clk_n;
  logic          fb_clk;
  logic          bus_en;

  int n_chk  = 0;
  int n_fail = 0;
  logic prev_x2, prev_en;

  always #10 clk = ~clk;

  clkdiv_busen #(.NUM_Q(NQ), .SYNC_STAGES(2)) u_clkdiv_busen (
    .clk(clk), .rst(rst), .pll_en(pll_en), .ref_in(ref_in),
    .x2_clk(x2_clk), .q_clk(q_clk), .q_clk_n(q_clk_n),
    .fb_clk(fb_clk), .bus_en(bus_en)
  );

  // Expected {x2, q, q_n, fb, en} at phase 0..7
  localparam logic [4:0] EXP_TBL [8] = '{
    5'b11011, 5'b01010, 5'b10110, 5'b00111,
    5'b11001, 5'b01000, 5'b10100, 5'b00101
  };

  function automatic logic [4:0] outs();
    return {x2_clk, q_clk[0], q_clk_n, fb_clk, bus_en};
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_equal_q(input string tag);
    n_chk++;
    if (q_clk !== {NQ{q_clk[0]}}) begin
      n_fail++;
      $display("FAIL %s: q_clk %b expected all equal", tag, q_clk);
    end
  endtask

  task automatic chk_en_edge(input string tag);
    n_chk++;
    if ((bus_en !== prev_en) && !(prev_x2 === 1'b1 && x2_clk === 1'b0)) begin
      n_fail++;
      $display("FAIL %s: bus_en %b->%b with x2 %b->%b, expected change only on x2 fall",
               tag, prev_en, bus_en, prev_x2, x2_clk);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; pll_en = mode; ref_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state, sampled before the first post-reset edge
    do_reset(1'b1);
    chk("R1 reset", outs(), EXP_TBL[0]);
    chk_equal_q("R4 reset");

    // Normal mode: table walk over two full feedback periods (R2 R3 R5 R6 R7)
    prev_x2 = x2_clk; prev_en = bus_en;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      chk($sformatf("R2 R3 R5 R6 R7 phase %0d", i % 8), outs(), EXP_TBL[i % 8]);
      chk_equal_q("R4 normal");
      chk_en_edge("R7 normal");
      prev_x2 = x2_clk; prev_en = bus_en;
    end

    // Reference toggling in normal mode has no effect on the stepping
    for (int i = 17; i <= 24; i++) begin
      ref_in = ~ref_in;
      @(negedge clk);
      chk("R2 ref ignored", outs(), EXP_TBL[i % 8]);
    end

    // Reset mid-run realigns to phase 0 (R1)
    @(negedge clk); @(negedge clk); @(negedge clk);
    do_reset(1'b1);
    chk("R1 realign", outs(), EXP_TBL[0]);

    // Test mode: one step per reference rising edge (R8)
    do_reset(1'b0);
    chk("R1 test-mode reset", outs(), EXP_TBL[0]);
    repeat (5) @(negedge clk);
    chk("R8 hold low", outs(), EXP_TBL[0]);
    prev_x2 = x2_clk; prev_en = bus_en;
    for (int k = 1; k <= 9; k++) begin
      ref_in = 1'b1;
      @(negedge clk); @(negedge clk);
      chk($sformatf("R8 before step %0d", k), outs(), EXP_TBL[(k - 1) % 8]);
      @(negedge clk);
      chk($sformatf("R8 after step %0d", k), outs(), EXP_TBL[k % 8]);
      chk_en_edge("R7 test mode");
      chk_equal_q("R4 test mode");
      prev_x2 = x2_clk; prev_en = bus_en;
      repeat (4) @(negedge clk);
      chk($sformatf("R8 hold high %0d", k), outs(), EXP_TBL[k % 8]);
      ref_in = 1'b0;
      repeat (5) @(negedge clk);
      chk($sformatf("R8 hold low %0d", k), outs(), EXP_TBL[k % 8]);
    end

    // Back to normal mode: stepping resumes from the held phase (R2)
    pll_en = 1'b1;
    @(negedge clk);
    chk("R2 resume", outs(), EXP_TBL[2]);
    @(negedge clk);
    chk("R2 resume next", outs(), EXP_TBL[3]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule